// File: doc/BRIEF.md
# Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters for a processor. The line is brought into the clock domain through a short synchronizer chain and then sampled on receive-clock ticks. Each bit lasts a fixed number of ticks, set by a selectable baud factor. A falling line starts a character. The receiver confirms the start bit at its midpoint, takes each data bit at its centre, least significant bit first, optionally takes a parity bit, and finally samples the stop bit.

A finished character goes into a holding register and raises a ready flag. The flag stays up until the processor reads the character. A character that completes while the previous one is still unread replaces it and sets an overrun flag. A low stop bit sets a framing flag, and a parity mismatch sets a parity flag. All three flags stay set until a clear strobe. If the stop positions of two characters in a row are both low, the line is held in a break and a break output rises. That output falls only when the line returns high.

The character format comes from static mode inputs: the baud factor, the character length, parity enable and parity sense. These inputs are expected to stay constant while a character is being received.

Top module: `rxa_receiver`

## Requirements
- R1: After reset, rx_data is 0 and rx_ready, ovr_err, frm_err, par_err and brk_det are all low.
- R2: The baud factor is 8 << baud_sel receive ticks per bit (baud_sel 0..3 gives 8, 16, 32, 64). A start is detected on a tick that sees the synchronized line low. It is confirmed only if the line is still low half a bit period (factor/2 ticks) later; otherwise the receiver returns to idle and produces no character.
- R3: The character length is 5 + len_sel bits. Data bits are sampled a full bit period apart, starting one bit period after the start confirmation, and are received least significant bit first. rx_data holds the character right-aligned, with the unused upper bits zero.
- R4: When par_en is 1, one parity bit follows the data. With par_odd 0 the expected parity bit is the XOR of the data bits (even parity); with par_odd 1 it is the inverse (odd parity). A mismatch sets par_err. When par_en is 0, par_err is never set.
- R5: A stop bit that is sampled low sets frm_err.
- R6: rx_ready rises one clock after the stop-bit sampling edge, together with the new rx_data. It falls one clock after an rd_strobe, unless a new character completes in that same cycle.
- R7: When a character completes while rx_ready is high and rd_strobe is low, rx_data takes the new character and ovr_err is set.
- R8: err_clr clears ovr_err, frm_err and par_err on the next clock edge. If a new error arrives in the same cycle as the clear, that flag is left set.
- R9: brk_det rises when the stop bits of two consecutive characters are both sampled low. It falls on the clock edge after the synchronized line is seen high.
- R10: Without rx_tick pulses the receiver does not detect starts and does not advance through a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_tick | input | 1 | Receive clock enable, one pulse per receive clock period |
| rxd | input | 1 | Serial receive line, idle high |
| baud_sel | input | 2 | Baud factor select, factor = 8 << baud_sel |
| len_sel | input | 2 | Character length select, length = 5 + len_sel |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 for odd parity, 0 for even parity |
| rd_strobe | input | 1 | Processor read of the held character |
| err_clr | input | 1 | Clear for the overrun, framing and parity flags |
| rx_data | output | 8 | Held character, right-aligned |
| rx_ready | output | 1 | A character is waiting to be read |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing flag |
| par_err | output | 1 | Parity flag |
| brk_det | output | 1 | Break detected on the line |

## Verification
A change on rxd reaches the sampler two clock edges later. Each sample is taken on the first tick after the counted number of ticks has elapsed. The character, rx_ready and the error flags change one edge after the stop sample. rd_strobe and err_clr take effect on the next edge. brk_det falls on the edge after the synchronized line goes high, which is the third rising edge after rxd rises. The bench model steps through the same edge counts at every rising edge, and the bench compares every output at the following falling edge. The targeted checks are placed a full idle bit after each frame, or a few cycles after a strobe, so that they fall well clear of those edges.

// File: rtl/rxa_pkg.sv
`timescale 1ns/1ps
package rxa_pkg;

    localparam int CHAR_MAX = 8;
    localparam int IDX_W    = $clog2(CHAR_MAX);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                perr;
        logic                ferr;
    } rx_char_t;

endpackage

// File: rtl/rxa_sync.sv
`timescale 1ns/1ps
module rxa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("sync chain needs at least two stages");
    end
endmodule

// File: rtl/rxa_framer.sv
`timescale 1ns/1ps
module rxa_framer
    import rxa_pkg::*;
#(
    parameter int BASE_FACTOR = 8,
    localparam int CNT_W = $clog2(BASE_FACTOR * 8) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_tick,
    input  logic       rx_s,
    input  logic [1:0] baud_sel,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       done,
    output rx_char_t   result
);
    typedef struct packed {
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [CHAR_MAX-1:0] sh;
        logic                par;
        logic                done;
        rx_char_t            res;
    } fr_t;

    fr_t fr_d, fr_q;

    logic [CNT_W-1:0] factor;
    logic [CNT_W-1:0] target;
    logic [IDX_W-1:0] last_idx;
    logic             hit;
    logic             exp_par;

    always_comb begin
        factor   = CNT_W'(BASE_FACTOR) << baud_sel;
        target   = (fr_q.st == ST_START) ? (factor >> 1) : factor;
        last_idx = IDX_W'(4) + IDX_W'(len_sel);
        hit      = rx_tick && (fr_q.cnt == target - CNT_W'(1));
        exp_par  = (^fr_q.sh) ^ par_odd;

        fr_d      = fr_q;
        fr_d.done = 1'b0;

        if (fr_q.st == ST_IDLE) begin
            if (rx_tick && !rx_s) begin
                fr_d.st  = ST_START;
                fr_d.cnt = '0;
            end
        end else if (rx_tick) begin
            if (!hit) begin
                fr_d.cnt = fr_q.cnt + CNT_W'(1);
            end else begin
                fr_d.cnt = '0;
                case (fr_q.st)
                    ST_START: begin
                        if (!rx_s) begin
                            fr_d.st  = ST_DATA;
                            fr_d.idx = '0;
                            fr_d.sh  = '0;
                        end else begin
                            fr_d.st = ST_IDLE;
                        end
                    end
                    ST_DATA: begin
                        fr_d.sh[fr_q.idx] = rx_s;
                        fr_d.idx          = fr_q.idx + IDX_W'(1);
                        if (fr_q.idx == last_idx)
                            fr_d.st = par_en ? ST_PAR : ST_STOP;
                    end
                    ST_PAR: begin
                        fr_d.par = rx_s;
                        fr_d.st  = ST_STOP;
                    end
                    ST_STOP: begin
                        fr_d.done     = 1'b1;
                        fr_d.res.data = fr_q.sh;
                        fr_d.res.perr = par_en && (fr_q.par != exp_par);
                        fr_d.res.ferr = !rx_s;
                        fr_d.st       = ST_IDLE;
                    end
                    default: fr_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q    <= '0;
            fr_q.st <= ST_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign done   = fr_q.done;
    assign result = fr_q.res;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.done |=> !fr_q.done); // R2
    AST_START_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == ST_DATA && $past(fr_q.st) == ST_START) |-> !$past(rx_s)); // R2
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == ST_DATA) |-> (fr_q.idx <= last_idx)); // R3
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_tick |=> $stable(fr_q.st)); // R10
endmodule

// File: rtl/rxa_hold.sv
`timescale 1ns/1ps
module rxa_hold
    import rxa_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  rx_char_t            result,
    input  logic                rd_strobe,
    input  logic                err_clr,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                ovr_err,
    output logic                frm_err,
    output logic                par_err
);
    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                ready;
        logic                ovr;
        logic                fe;
        logic                pe;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (err_clr) begin
            hd_d.ovr = 1'b0;
            hd_d.fe  = 1'b0;
            hd_d.pe  = 1'b0;
        end
        if (done) begin
            if (hd_q.ready && !rd_strobe) hd_d.ovr = 1'b1;
            if (result.ferr)              hd_d.fe  = 1'b1;
            if (result.perr)              hd_d.pe  = 1'b1;
            hd_d.data  = result.data;
            hd_d.ready = 1'b1;
        end else if (rd_strobe) begin
            hd_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign rx_data  = hd_q.data;
    assign rx_ready = hd_q.ready;
    assign ovr_err  = hd_q.ovr;
    assign frm_err  = hd_q.fe;
    assign par_err  = hd_q.pe;

    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> hd_q.ready); // R6
    AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !done) |=> !hd_q.ready); // R6
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hd_q.ready && !rd_strobe) |=> hd_q.ovr); // R7
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !done) |=> (!hd_q.ovr && !hd_q.fe && !hd_q.pe)); // R8
endmodule

// File: rtl/rxa_break.sv
`timescale 1ns/1ps
module rxa_break (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_s,
    input  logic done,
    input  logic stop_low,
    output logic brk_det
);
    typedef struct packed {
        logic prev_low;
        logic brk;
    } brk_t;

    brk_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (rx_s) begin
            bk_d.prev_low = 1'b0;
            bk_d.brk      = 1'b0;
        end else if (done) begin
            if (stop_low) begin
                if (bk_q.prev_low) bk_d.brk = 1'b1;
                bk_d.prev_low = 1'b1;
            end else begin
                bk_d.prev_low = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign brk_det = bk_q.brk;

    AST_BRK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_s |=> !bk_q.brk); // R9
    AST_BRK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bk_q.brk) |-> ($past(done) && $past(stop_low))); // R9
endmodule

// File: rtl/rxa_receiver.sv
`timescale 1ns/1ps
module rxa_receiver
    import rxa_pkg::*;
#(
    parameter int BASE_FACTOR = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_tick,
    input  logic       rxd,
    input  logic [1:0] baud_sel,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_strobe,
    input  logic       err_clr,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       ovr_err,
    output logic       frm_err,
    output logic       par_err,
    output logic       brk_det
);
    logic     rx_s;
    logic     char_done;
    rx_char_t char_res;

    rxa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    rxa_framer #(.BASE_FACTOR(BASE_FACTOR)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_tick (rx_tick),
        .rx_s    (rx_s),
        .baud_sel(baud_sel),
        .len_sel (len_sel),
        .par_en  (par_en),
        .par_odd (par_odd),
        .done    (char_done),
        .result  (char_res)
    );

    rxa_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (char_done),
        .result   (char_res),
        .rd_strobe(rd_strobe),
        .err_clr  (err_clr),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .ovr_err  (ovr_err),
        .frm_err  (frm_err),
        .par_err  (par_err)
    );

    rxa_break u_break (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_s    (rx_s),
        .done    (char_done),
        .stop_low(char_res.ferr),
        .brk_det (brk_det)
    );

    AST_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_en && !par_err) |=> !par_err); // R4
endmodule

// File: tb/tb_rxa_receiver.sv
`timescale 1ns/1ps
module tb_rxa_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] baud_sel = 2'd0;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, ovr_err, frm_err, par_err, brk_det;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit tick_en = 1'b1;
    int tper = 1;
    int tph = 0;

    rxa_receiver dut (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd),
        .baud_sel(baud_sel), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
        .rx_ready(rx_ready), .ovr_err(ovr_err), .frm_err(frm_err),
        .par_err(par_err), .brk_det(brk_det)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!tick_en) begin
            rx_tick <= 1'b0;
        end else begin
            rx_tick <= (tph == 0);
            tph = (tph + 1) % tper;
        end
    end

    // behavioural reference: line history, sample countdown, held character
    int  m_l1, m_l2;
    int  m_mode, m_cnt, m_bit, m_word, m_pbit;
    bit  m_fin;
    int  m_fin_word;
    bit  m_fin_fe, m_fin_pe;
    int  m_data;
    bit  m_rdy, m_ovr, m_fe, m_pe, m_brk, m_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_l1 = 1; m_l2 = 1; m_mode = 0; m_cnt = 0; m_bit = 0; m_word = 0; m_pbit = 0;
            m_fin = 0; m_fin_word = 0; m_fin_fe = 0; m_fin_pe = 0;
            m_data = 0; m_rdy = 0; m_ovr = 0; m_fe = 0; m_pe = 0; m_brk = 0; m_prev = 0;
        end else begin
            int fac, len, goal;
            bit nf;
            fac = 8 << baud_sel;
            len = 5 + len_sel;
            if (err_clr) begin m_ovr = 0; m_fe = 0; m_pe = 0; end
            if (m_fin) begin
                if (m_rdy && !rd_strobe) m_ovr = 1;
                if (m_fin_fe) m_fe = 1;
                if (m_fin_pe) m_pe = 1;
                m_data = m_fin_word;
                m_rdy = 1;
            end else if (rd_strobe) m_rdy = 0;
            if (m_l2 == 1) begin m_prev = 0; m_brk = 0; end
            else if (m_fin) begin
                if (m_fin_fe) begin if (m_prev) m_brk = 1; m_prev = 1; end
                else m_prev = 0;
            end
            nf = 0;
            if (m_mode == 0) begin
                if (rx_tick && m_l2 == 0) begin m_mode = 1; m_cnt = 0; end
            end else if (rx_tick) begin
                goal = (m_mode == 1) ? fac / 2 : fac;
                if (m_cnt < goal - 1) m_cnt++;
                else begin
                    m_cnt = 0;
                    if (m_mode == 1) begin
                        if (m_l2 == 0) begin m_mode = 2; m_bit = 0; m_word = 0; end
                        else m_mode = 0;
                    end else if (m_mode == 2) begin
                        m_word = m_word | (m_l2 << m_bit);
                        if (m_bit == len - 1) m_mode = par_en ? 3 : 4;
                        m_bit++;
                    end else if (m_mode == 3) begin
                        m_pbit = m_l2; m_mode = 4;
                    end else begin
                        nf = 1;
                        m_fin_word = m_word;
                        m_fin_fe = (m_l2 == 0);
                        m_fin_pe = par_en && (m_pbit != ((^m_word[7:0]) ^ par_odd));
                        m_mode = 0;
                    end
                end
            end
            m_fin = nf;
            m_l2 = m_l1;
            m_l1 = rxd;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 model rx_data", rx_data, m_data);
            check("R6 model rx_ready", rx_ready, m_rdy);
            check("R7 model ovr_err", ovr_err, m_ovr);
            check("R5 model frm_err", frm_err, m_fe);
            check("R4 model par_err", par_err, m_pe);
            check("R9 model brk_det", brk_det, m_brk);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input bit v);
        rxd = v;
        wait_cyc((8 << baud_sel) * tper);
    endtask

    task automatic send_frame(input logic [7:0] ch, input bit flip_par, input bit stop_v);
        int len;
        len = 5 + len_sel;
        drive_bit(1'b0);
        for (int i = 0; i < len; i++) drive_bit(ch[i]);
        if (par_en) drive_bit(((^(ch & 8'((1 << len) - 1))) ^ par_odd) ^ flip_par);
        drive_bit(stop_v);
        drive_bit(1'b1);
    endtask

    task automatic pulse_rd_clr(input bit rd, input bit clr);
        rd_strobe = rd; err_clr = clr;
        wait_cyc(1);
        rd_strobe = 1'b0; err_clr = 1'b0;
        wait_cyc(1);
    endtask

    task automatic set_rate(input logic [1:0] bs, input int tp);
        baud_sel = bs; tper = tp; tph = 0;
        wait_cyc(2);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 reset rx_data", rx_data, 0);
        check("R1 reset rx_ready", rx_ready, 0);
        check("R1 reset flags", {ovr_err, frm_err, par_err}, 0);
        check("R1 reset brk_det", brk_det, 0);

        // 8-bit, no parity, factor 8
        send_frame(8'hA5, 0, 1);
        check("R3 eight-bit char", rx_data, 8'hA5);
        check("R6 ready after char", rx_ready, 1);
        pulse_rd_clr(1, 0);
        check("R6 ready cleared by read", rx_ready, 0);

        // 5-bit, even parity
        len_sel = 2'd0; par_en = 1'b1; par_odd = 1'b0;
        wait_cyc(2);
        send_frame(8'hF3, 0, 1);
        check("R3 five-bit right aligned", rx_data, 8'h13);
        check("R4 even parity ok", par_err, 0);
        pulse_rd_clr(1, 0);

        // 7-bit, odd parity, wrong parity bit
        len_sel = 2'd2; par_odd = 1'b1;
        wait_cyc(2);
        send_frame(8'h5B, 1, 1);
        check("R3 seven-bit char", rx_data, 8'h5B);
        check("R4 odd parity mismatch", par_err, 1);
        pulse_rd_clr(1, 1);
        check("R8 parity flag cleared", par_err, 0);

        // factor 16 with a tick every other clock, 6-bit even parity
        set_rate(2'd1, 2);
        len_sel = 2'd1; par_odd = 1'b0;
        send_frame(8'h2D, 0, 1);
        check("R2 factor sixteen char", rx_data, 8'h2D);
        check("R4 even parity good", par_err, 0);
        pulse_rd_clr(1, 0);

        // framing error, 8-bit no parity, factor 8
        set_rate(2'd0, 1);
        len_sel = 2'd3; par_en = 1'b0;
        wait_cyc(2);
        send_frame(8'h3C, 0, 0);
        wait_cyc(40);
        check("R5 low stop sets framing flag", frm_err, 1);
        check("R9 single low stop no break", brk_det, 0);
        wait_cyc(100);
        pulse_rd_clr(1, 1);
        check("R8 framing flag cleared", frm_err, 0);

        // overrun
        send_frame(8'h11, 0, 1);
        send_frame(8'h22, 0, 1);
        check("R7 newer char replaces", rx_data, 8'h22);
        check("R7 overrun flag", ovr_err, 1);
        pulse_rd_clr(1, 1);
        check("R8 overrun flag cleared", ovr_err, 0);
        check("R6 ready cleared", rx_ready, 0);

        // false start: short low glitch
        rxd = 1'b0; wait_cyc(3); rxd = 1'b1;
        wait_cyc(120);
        check("R2 glitch gives no char", rx_ready, 0);

        // no ticks: long low line leaves receiver idle
        tick_en = 1'b0;
        wait_cyc(2);
        rxd = 1'b0; wait_cyc(300); rxd = 1'b1; wait_cyc(10);
        tick_en = 1'b1; tph = 0;
        wait_cyc(40);
        check("R10 no char without ticks", rx_ready, 0);
        check("R10 no framing without ticks", frm_err, 0);
        check("R10 no break without ticks", brk_det, 0);

        // factor 64, 8-bit odd parity
        set_rate(2'd3, 1);
        par_en = 1'b1; par_odd = 1'b1;
        send_frame(8'hC6, 0, 1);
        check("R2 factor sixty-four char", rx_data, 8'hC6);
        check("R4 odd parity good", par_err, 0);
        pulse_rd_clr(1, 0);

        // break: line held low over several characters
        set_rate(2'd0, 1);
        par_en = 1'b0;
        rxd = 1'b0;
        wait_cyc(320);
        check("R9 break raised", brk_det, 1);
        check("R5 break char framing", frm_err, 1);
        check("R3 break char all zero", rx_data, 0);
        rxd = 1'b1;
        wait_cyc(4);
        check("R9 break dropped on high line", brk_det, 0);
        wait_cyc(200);
        pulse_rd_clr(1, 1);
        check("R8 all flags cleared", {ovr_err, frm_err, par_err}, 0);

        wait_cyc(5);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule